// File: doc/BRIEF.md
# Byte-Serial Pattern-ROM Emulation Port

This block makes a window of ordinary byte RAM look like a byte-serial graphics ROM to an 8-bit CPU. Software reaches it through two ports on the CPU bus. The address port loads a 16-bit pointer one byte at a time and reads it back one byte at a time. The data port fetches the RAM byte that the pointer selects, and every data access moves the pointer on by one.

The emulated space is a 64 KB window that starts at physical byte 0x70000. The pointer is added to that base to form a 20-bit RAM address. The emulation has no look-ahead byte. To make up for this, loading the low pointer byte also adds one to the pointer, so the stored image is shifted by one byte: RAM byte 0 of the window holds the content of pointer value 0xFFFF.

The pointer wraps at 16 bits. The write-side and read-side byte toggles are kept apart, and each kind of access clears the other's toggle. Address decode above the port and the RAM itself lie outside the block.

Top module: `grom_emu_port`

## Requirements
- R1: After reset the pointer is 0x0000 and both byte toggles are clear, so the first two address-port reads return 0x00 and 0x00. `ready` is low during reset.
- R2: Address-port writes (`portAddr` = 2'b10) load the high pointer byte first and the low byte second. Loading the low byte leaves the pointer at {high, low} + 1.
- R3: Address-port reads (`portAddr` = 2'b10) return the high pointer byte first and the low byte second, alternating on a read toggle.
- R4: An address-port write clears the read toggle, and an address-port read clears the write toggle.
- R5: A data-port read (`portAddr` = 2'b00) asserts `memRd` in the strobe cycle with `memAddr` = 0x70000 + pointer. One cycle later, `rdData` carries `memData`. The pointer then increases by one.
- R6: The pointer wraps from 0xFFFF to 0x0000, whether it is advanced by a data access or by a low-byte load.
- R7: A data-port write stores nothing: `memRd` stays low and `rdData` is 0x00. The pointer still increases by one.
- R8: Any data-port access, read or write, clears both byte toggles.
- R9: An access with `portAddr[0]` = 1 changes no state, does not assert `memRd`, and returns 0x00.
- R10: `ready` is high exactly in the cycle after each read or write strobe, and `rdData` is valid in that cycle. If both strobes are high together, the read takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdStb | input | 1 | One-cycle CPU read strobe |
| wrStb | input | 1 | One-cycle CPU write strobe |
| portAddr | input | 2 | Low CPU address bits: bit 1 selects address port (1) or data port (0); bit 0 must be 0 |
| wrData | input | 8 | CPU write byte |
| rdData | output | 8 | CPU read byte, valid while `ready` is high |
| ready | output | 1 | Access completion, one cycle after the strobe |
| memRd | output | 1 | RAM read request |
| memAddr | output | 20 | RAM byte address |
| memData | input | 8 | RAM read byte, valid one cycle after `memRd` |

## Verification
The bench targets the corner cases below and what a faulty design would do in each:

- **Cross-clearing of the two toggles.** A design that shares one toggle, or never clears the other, loads a high byte into the low half or returns the low byte first after a write.
- **Post-load increment.** Leaving it out makes every read-back come out one less than expected.
- **Wrap at 0xFFFF.** A design that wraps inside an 8 KB region, or carries into the base, sends the next fetch to the wrong RAM page.
- **Odd-address accesses.** A design that lets them through advances the pointer or flips a toggle, and the read-back sequence that follows them shows it.

// File: rtl/grom_emu_pkg.sv
package grom_emu_pkg;
  // strobes from the control section to the pointer datapath
  typedef struct packed {
    logic loadHi;   // load high pointer byte
    logic loadLo;   // load low pointer byte and add one
    logic bump;     // advance pointer by one
    logic capHi;    // capture high pointer byte for read-back
    logic capLo;    // capture low pointer byte for read-back
    logic useMem;   // next read byte comes from RAM
  } dpCtl_t;
endpackage

// File: rtl/grom_emu_ctrl.sv
module grom_emu_ctrl
  import grom_emu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [1:0] portAddr,
  output dpCtl_t     ctl,
  output logic       memRd,
  output logic       ready
);
  logic wPhase, rPhase, readyQ;
  logic hit, isAddr, addrWr, addrRd, dataRd, dataWr;

  always_comb begin
    hit    = (rdStb | wrStb) & ~portAddr[0];
    isAddr = portAddr[1];
    addrRd = hit & rdStb & isAddr;
    dataRd = hit & rdStb & ~isAddr;
    addrWr = hit & ~rdStb & wrStb & isAddr;
    dataWr = hit & ~rdStb & wrStb & ~isAddr;
    ctl        = '0;
    ctl.loadHi = addrWr & ~wPhase;
    ctl.loadLo = addrWr & wPhase;
    ctl.bump   = dataRd | dataWr;
    ctl.capHi  = addrRd & ~rPhase;
    ctl.capLo  = addrRd & rPhase;
    ctl.useMem = dataRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wPhase <= 1'b0;
      rPhase <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      if (addrWr)
        wPhase <= ~wPhase;
      else if (addrRd | dataRd | dataWr)
        wPhase <= 1'b0;

      if (addrRd)
        rPhase <= ~rPhase;
      else if (addrWr | dataRd | dataWr)
        rPhase <= 1'b0;

      readyQ <= rdStb | wrStb;
    end
  end

  assign memRd = dataRd;
  assign ready = readyQ;
endmodule

// File: rtl/grom_emu_dp.sv
module grom_emu_dp
  import grom_emu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 20,
  parameter logic [PHYS_W-1:0] BASE = 20'h70000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              ready,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rdData,
  output logic [PHYS_W-1:0] memAddr
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam int PAD  = PHYS_W - ADDR_W;

  logic [ADDR_W-1:0] gplAddr;
  logic [DATA_W-1:0] holdQ;
  logic              memSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gplAddr <= '0;
      holdQ   <= '0;
      memSelQ <= 1'b0;
    end else begin
      if (ctl.loadHi)
        gplAddr <= {wrData[HI_W-1:0], gplAddr[DATA_W-1:0]};
      else if (ctl.loadLo)
        gplAddr <= {gplAddr[ADDR_W-1:DATA_W], wrData} + 1'b1;
      else if (ctl.bump)
        gplAddr <= gplAddr + 1'b1;

      if (ctl.capHi)
        holdQ <= DATA_W'(gplAddr[ADDR_W-1:DATA_W]);
      else if (ctl.capLo)
        holdQ <= gplAddr[DATA_W-1:0];
      else
        holdQ <= '0;

      memSelQ <= ctl.useMem;
    end
  end

  assign memAddr = BASE + {{PAD{1'b0}}, gplAddr};
  assign rdData  = !ready ? '0 : (memSelQ ? memData : holdQ);
endmodule

// File: rtl/grom_emu_port.sv
module grom_emu_port
  import grom_emu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int PHYS_W = 20,
  parameter logic [PHYS_W-1:0] BASE = 20'h70000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [1:0]        portAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready,
  output logic              memRd,
  output logic [PHYS_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData
);
  dpCtl_t ctl;

  grom_emu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb),
    .portAddr(portAddr), .ctl(ctl), .memRd(memRd), .ready(ready)
  );

  grom_emu_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PHYS_W(PHYS_W), .BASE(BASE)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ready(ready), .wrData(wrData),
    .memData(memData), .rdData(rdData), .memAddr(memAddr)
  );
endmodule

// File: rtl/grom_emu_chk.sv
module grom_emu_chk #(
  parameter int DATA_W = 8,
  parameter int PHYS_W = 20,
  parameter logic [PHYS_W-1:0] BASE = 20'h70000
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStb,
  input logic              wrStb,
  input logic [1:0]        portAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              ready,
  input logic              memRd,
  input logic [PHYS_W-1:0] memAddr
);
  AST_READY_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb | wrStb) |=> ready);                                           // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb | wrStb) |=> !ready);                                         // R10
  AST_MEMRD_ONLY_DATA_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (rdStb && portAddr == 2'b00));                              // R5
  AST_MEM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> (memAddr[PHYS_W-1:16] == BASE[PHYS_W-1:16]));               // R5
  AST_BACK_TO_BACK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr[15:0] == $past(memAddr[15:0]) + 16'd1)); // R6
  AST_ODD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStb | wrStb) && portAddr[0]) |-> !memRd);                         // R9
  AST_ODD_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && portAddr[0]) |=> (rdData == '0));                           // R9
  AST_NO_DATA_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (rdData == '0));                                           // R10
endmodule

bind grom_emu_port grom_emu_chk #(.DATA_W(DATA_W), .PHYS_W(PHYS_W), .BASE(BASE)) uChk (
  .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .portAddr(portAddr),
  .rdData(rdData), .ready(ready), .memRd(memRd), .memAddr(memAddr)
);

// File: tb/tb_grom_emu_port.sv
module tb_grom_emu_port;
  localparam logic [19:0] BASE = 20'h70000;
  localparam logic [1:0] P_ADDR = 2'b10;
  localparam logic [1:0] P_DATA = 2'b00;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdStb = 1'b0, wrStb = 1'b0;
  logic [1:0] portAddr = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData, memData;
  logic       ready, memRd;
  logic [19:0] memAddr;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  grom_emu_port dut (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .portAddr(portAddr),
    .wrData(wrData), .rdData(rdData), .ready(ready), .memRd(memRd),
    .memAddr(memAddr), .memData(memData)
  );

  function automatic logic [7:0] memFn(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h3};
  endfunction

  // RAM model with one clock of read latency
  always_ff @(posedge clk) if (memRd) memData <= memFn(memAddr);
  initial memData = 8'h00;

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [7:0]  qRd;
  logic [19:0] qMa;
  logic        qMr;

  task automatic access(input logic w, input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    rdStb = !w; wrStb = w; portAddr = p; wrData = d;
    #1 qMa = memAddr; qMr = memRd;
    @(negedge clk);
    rdStb = 1'b0; wrStb = 1'b0;
    qRd = rdData;
    check("R10 ready after strobe", {19'd0, ready}, 20'd1);
  endtask

  task automatic wa(input logic [7:0] d); access(1'b1, P_ADDR, d); endtask
  task automatic ra(input logic [7:0] e, input string req);
    access(1'b0, P_ADDR, 8'h00);
    check(req, {12'd0, qRd}, {12'd0, e});
    check("R5 no memRd on address read", {19'd0, qMr}, 20'd0);
  endtask
  task automatic rdm(input logic [15:0] a, input string req);
    access(1'b0, P_DATA, 8'h00);
    check(req, qMa, BASE | {4'd0, a});
    check(req, {19'd0, qMr}, 20'd1);
    check(req, {12'd0, qRd}, {12'd0, memFn(BASE | {4'd0, a})});
  endtask
  task automatic wd(input string req);
    access(1'b1, P_DATA, 8'hA5);
    check(req, {19'd0, qMr}, 20'd0);
    check(req, {12'd0, qRd}, 20'd0);
  endtask

  typedef struct packed {
    logic       w;
    logic [1:0] p;
    logic [7:0] d;
    logic [1:0] chk;   // 0 none, 1 literal byte, 2 RAM byte at BASE+e
    logic [15:0] e;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 2'b10, 8'h12, 2'd0, 16'h0000},  // R2 high byte
    '{1'b1, 2'b10, 8'h34, 2'd0, 16'h0000},  // R2 low byte, pointer 1235
    '{1'b0, 2'b10, 8'h00, 2'd1, 16'h0012},  // R3 high first
    '{1'b0, 2'b10, 8'h00, 2'd1, 16'h0035},  // R2 R3 low has +1
    '{1'b0, 2'b00, 8'h00, 2'd2, 16'h1235},  // R5 data read
    '{1'b0, 2'b10, 8'h00, 2'd1, 16'h0012},  // R8 read toggle cleared
    '{1'b0, 2'b10, 8'h00, 2'd1, 16'h0036},  // R5 pointer advanced
    '{1'b1, 2'b00, 8'h77, 2'd0, 16'h0000},  // R7 data write
    '{1'b0, 2'b10, 8'h00, 2'd1, 16'h0012},
    '{1'b0, 2'b10, 8'h00, 2'd1, 16'h0037}   // R7 pointer advanced
  };

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {19'd0, ready}, 20'd0);
    check("R1 memRd low in reset", {19'd0, memRd}, 20'd0);
    rstN = 1'b1;
    ra(8'h00, "R1 pointer high after reset");
    ra(8'h00, "R1 pointer low after reset");
    @(negedge clk);
    check("R10 ready drops when idle", {19'd0, ready}, 20'd0);

    // vector table
    foreach (VEC[i]) begin
      access(VEC[i].w, VEC[i].p, VEC[i].d);
      if (VEC[i].chk == 2'd1)
        check("R2 R3 vector read-back", {12'd0, qRd}, {12'd0, VEC[i].e[7:0]});
      else if (VEC[i].chk == 2'd2) begin
        check("R5 vector memAddr", qMa, BASE | {4'd0, VEC[i].e});
        check("R5 vector data", {12'd0, qRd}, {12'd0, memFn(BASE | {4'd0, VEC[i].e})});
      end
      if (VEC[i].w && VEC[i].p == P_DATA)
        check("R7 data write reads zero and no memRd", {11'd0, qMr, qRd}, 20'd0);
    end

    // R4 address read clears write toggle
    wa(8'hAB);
    ra(8'hAB, "R4 read after high load");
    wa(8'hCD);          // high again
    wa(8'hEF);          // CDEF + 1
    ra(8'hCD, "R4 write toggle cleared by read");
    ra(8'hF0, "R4 low after reload");
    // R4 address write clears read toggle
    ra(8'hCD, "R4 read toggle set");
    wa(8'h11);
    wa(8'h22);          // 1123
    ra(8'h11, "R4 read toggle cleared by write");
    ra(8'h23, "R4 low");

    // R8 data accesses clear both toggles
    ra(8'h11, "R8 setup");
    rdm(16'h1123, "R8 data read");
    ra(8'h11, "R8 read toggle cleared by data read");
    wa(8'h77);          // pointer 7724, write toggle set
    wd("R7 data write");
    wa(8'h88);          // high again: 8825
    wa(8'h99);          // 889A
    ra(8'h88, "R8 write toggle cleared by data write");
    ra(8'h9A, "R8 low");

    // R6 wrap
    wa(8'hFF); wa(8'hFE);  // FFFF
    rdm(16'hFFFF, "R6 read at top of window");
    ra(8'h00, "R6 wrap high");
    ra(8'h00, "R6 wrap low");
    wa(8'hFF); wa(8'hFF);  // FFFF + 1
    ra(8'h00, "R6 low-load wrap high");
    ra(8'h00, "R6 low-load wrap low");

    // R9 odd accesses ignored
    wa(8'h40);
    access(1'b1, 2'b11, 8'h99);
    wa(8'h50);          // still low byte: 4051
    access(1'b0, 2'b01, 8'h00);
    check("R9 odd read returns zero", {12'd0, qRd}, 20'd0);
    check("R9 odd read no memRd", {19'd0, qMr}, 20'd0);
    access(1'b0, 2'b11, 8'h00);
    check("R9 odd address-port read returns zero", {12'd0, qRd}, 20'd0);
    ra(8'h40, "R9 state unchanged high");
    ra(8'h51, "R9 state unchanged low");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule